// File: doc/BRIEF.md
# PCI Interrupt Router and CPU Trigger

This block takes interrupt events raised by devices on a PCI bus and turns them into the single interrupt request seen by the processor. Each event names the device slot (5 bits) and the interrupt pin (0 to 3 for INTA to INTD). A fixed, slot-specific table turns that pair into an internal line number. Lines are numbered from a base of 32, so the bit for a line in the configuration words is at index line − 32. The same pin on neighbouring expansion slots lands on different lines, so the load is spread across them.

Two 32-bit configuration words choose, for each line, how an event is delivered. If the line's bit in the edge word is set, the event gives a one-cycle pulse on the CPU output. If it is clear, the line is level mode: the output goes high if the line's bit in the polarity word is set, and low otherwise. The output keeps that value until a later event changes it. An event whose line falls below the base has no bit to select, so it changes nothing.

The trigger is a three-state machine. QUIET drives the output low and ASSERTED drives it high. PULSE drives it high for exactly one cycle. Transitions happen only on a strobe whose line is in range:
- go_pulse: edge bit set, to PULSE.
- go_assert: level mode with polarity set, to ASSERTED.
- go_quiet: level mode with polarity clear, to QUIET.

Two more transitions need no strobe or an ignored one. pulse_done takes PULSE to QUIET at the end of the pulse. hold keeps QUIET or ASSERTED where they are.

Top module: `irq_router`

## Requirements
- R1: Slot 5 maps pin p (0..3) to line 32 + p.
- R2: Slot 6 maps to line 36 and slot 7 maps to line 37, whatever the pin.
- R3: Slots 8 to 12 map pin p to line 38 + (slot − 8) + p, so slot 12 pin 3 gives line 45.
- R4: Any other slot gives a line number equal to the pin number. `line_num` is combinational from `evt_slot` and `evt_pin`.
- R5: A strobed event whose line is below 32 leaves `cpu_irq` unchanged, whether it was high or low.
- R6: A strobed event on a line whose edge bit is set makes `cpu_irq` high in the cycle after the strobe. With no further event, it is low in the cycle after that. Edge events on back-to-back cycles keep it high for each of those cycles.
- R7: A strobed event on a level-mode line whose polarity bit is set drives `cpu_irq` high from the next cycle. It stays high until another in-range event changes it.
- R8: A strobed event on a level-mode line whose polarity bit is clear drives `cpu_irq` low from the next cycle.
- R9: While `rst_n` is low, and after reset until the first in-range event, `cpu_irq` is low.
- R10: The edge and polarity bits used for an event are the ones at index line − 32 and no others. For example, slot 12 pin 3 uses bit 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_stb | input | 1 | One-cycle strobe marking an interrupt event |
| evt_slot | input | 5 | Slot number of the device raising the event |
| evt_pin | input | 2 | Interrupt pin, 0 to 3 for INTA to INTD |
| edge_cfg | input | 32 | Per-line edge-mode bits, indexed by line − 32 |
| pol_cfg | input | 32 | Per-line polarity bits for level mode, indexed by line − 32 |
| line_num | output | 6 | Mapped internal line number |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that `edge_cfg` and `pol_cfg` do not change in the cycle an event is strobed. They also assume that slot and pin are valid whenever `evt_stb` is high, because the expected next state is worked out from the bits selected in that cycle. The bench changes configuration only while the strobe is low, and it drives every input at the falling edge so each strobe lasts exactly one rising edge. Back-to-back strobes are used on purpose, to check that an edge pulse running into a new event behaves as R6 states.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [1:0] {
        ST_QUIET    = 2'd0,
        ST_ASSERTED = 2'd1,
        ST_PULSE    = 2'd2
    } trig_state_e;

    // Per-event delivery attributes after the configuration bit lookup
    typedef struct packed {
        logic in_range;
        logic is_edge;
        logic pol_high;
    } evt_attr_t;

endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map #(
    parameter int SLOT_W       = 5,
    parameter int PIN_W        = 2,
    parameter int LINE_W       = 6,
    parameter int LINE_BASE    = 32,
    parameter int SB_SLOT      = 5,
    parameter int GFX_SLOT     = 6,
    parameter int NIC_SLOT     = 7,
    parameter int EXP_FIRST    = 8,
    parameter int EXP_LAST     = 12,
    parameter int GFX_OFS      = 4,
    parameter int NIC_OFS      = 5,
    parameter int EXP_OFS      = 6
) (
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [PIN_W-1:0]  pin_i,
    output logic [LINE_W-1:0] line_o
);

    localparam int PIN_COUNT = 1 << PIN_W;

    int slot_v;
    int pin_v;

    always_comb begin
        slot_v = int'(slot_i);
        pin_v  = int'(pin_i);
        if (slot_v == SB_SLOT) begin
            line_o = LINE_W'(LINE_BASE + (pin_v % PIN_COUNT));
        end else if (slot_v == GFX_SLOT) begin
            line_o = LINE_W'(LINE_BASE + GFX_OFS);
        end else if (slot_v == NIC_SLOT) begin
            line_o = LINE_W'(LINE_BASE + NIC_OFS);
        end else if (slot_v >= EXP_FIRST && slot_v <= EXP_LAST) begin
            line_o = LINE_W'(LINE_BASE + EXP_OFS + (slot_v - EXP_FIRST) + pin_v);
        end else begin
            line_o = LINE_W'(pin_v);
        end
    end

endmodule

// File: rtl/irq_cfg_select.sv
module irq_cfg_select
    import irq_route_pkg::*;
#(
    parameter int LINE_W    = 6,
    parameter int CFG_W     = 32,
    parameter int LINE_BASE = 32
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [CFG_W-1:0]  edge_cfg_i,
    input  logic [CFG_W-1:0]  pol_cfg_i,
    output evt_attr_t         attr_o
);

    localparam int IDX_W = $clog2(CFG_W);

    int               offs;
    logic [IDX_W-1:0] sel;

    always_comb begin
        offs            = int'(line_i) - LINE_BASE;
        sel             = IDX_W'(offs);
        attr_o.in_range = (offs >= 0) && (offs < CFG_W);
        attr_o.is_edge  = attr_o.in_range && edge_cfg_i[sel];
        attr_o.pol_high = attr_o.in_range && pol_cfg_i[sel];
    end

endmodule

// File: rtl/irq_trigger_fsm.sv
module irq_trigger_fsm
    import irq_route_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stb_i,
    input  evt_attr_t attr_i,
    output logic      irq_o
);

    trig_state_e state_q;
    trig_state_e state_d;
    trig_state_e on_event;
    logic        take;

    // Target state when an in-range event arrives
    always_comb begin
        take = stb_i && attr_i.in_range;
        if (attr_i.is_edge) begin
            on_event = ST_PULSE;      // go_pulse
        end else if (attr_i.pol_high) begin
            on_event = ST_ASSERTED;   // go_assert
        end else begin
            on_event = ST_QUIET;      // go_quiet
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:    state_d = take ? on_event : ST_QUIET;     // hold
            ST_ASSERTED: state_d = take ? on_event : ST_ASSERTED;  // hold
            ST_PULSE:    state_d = take ? on_event : ST_QUIET;     // pulse_done
            default:     state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore output
    always_comb begin
        unique case (state_q)
            ST_ASSERTED, ST_PULSE: irq_o = 1'b1;
            default:               irq_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_route_pkg::*;
#(
    parameter int SLOT_W    = 5,
    parameter int PIN_W     = 2,
    parameter int CFG_W     = 32,
    parameter int LINE_BASE = 32,
    parameter int LINE_W    = $clog2(LINE_BASE + CFG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_stb,
    input  logic [SLOT_W-1:0] evt_slot,
    input  logic [PIN_W-1:0]  evt_pin,
    input  logic [CFG_W-1:0]  edge_cfg,
    input  logic [CFG_W-1:0]  pol_cfg,
    output logic [LINE_W-1:0] line_num,
    output logic              cpu_irq
);

    evt_attr_t attr;

    irq_slot_map #(
        .SLOT_W    (SLOT_W),
        .PIN_W     (PIN_W),
        .LINE_W    (LINE_W),
        .LINE_BASE (LINE_BASE)
    ) u_map (
        .slot_i (evt_slot),
        .pin_i  (evt_pin),
        .line_o (line_num)
    );

    irq_cfg_select #(
        .LINE_W    (LINE_W),
        .CFG_W     (CFG_W),
        .LINE_BASE (LINE_BASE)
    ) u_sel (
        .line_i     (line_num),
        .edge_cfg_i (edge_cfg),
        .pol_cfg_i  (pol_cfg),
        .attr_o     (attr)
    );

    irq_trigger_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (evt_stb),
        .attr_i (attr),
        .irq_o  (cpu_irq)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int SLOT_W    = 5,
    parameter int PIN_W     = 2,
    parameter int CFG_W     = 32,
    parameter int LINE_BASE = 32,
    parameter int LINE_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_stb,
    input logic [SLOT_W-1:0] evt_slot,
    input logic [PIN_W-1:0]  evt_pin,
    input logic [CFG_W-1:0]  edge_cfg,
    input logic [CFG_W-1:0]  pol_cfg,
    input logic [LINE_W-1:0] line_num,
    input logic              cpu_irq
);

    localparam int IDX_W = $clog2(CFG_W);

    int               ofs;
    logic             in_rng;
    logic             e_bit;
    logic             p_bit;
    logic [IDX_W-1:0] idx;

    always_comb begin
        ofs    = int'(line_num) - LINE_BASE;
        idx    = IDX_W'(ofs);
        in_rng = (ofs >= 0) && (ofs < CFG_W);
        e_bit  = edge_cfg[idx];
        p_bit  = pol_cfg[idx];
    end

    // R6
    edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stb && in_rng && e_bit) |=> cpu_irq);

    // R6
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stb && in_rng && e_bit) ##1 !evt_stb |=> !cpu_irq);

    // R7
    level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stb && in_rng && !e_bit && p_bit) |=> cpu_irq);

    // R8
    level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stb && in_rng && !e_bit && !p_bit) |=> !cpu_irq);

    // R5
    ignored_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stb && !in_rng && !cpu_irq) |=> !cpu_irq);

    // R9
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past(evt_stb));

    // R2
    fixed_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(evt_slot) == 6) |-> (int'(line_num) == LINE_BASE + 4));

endmodule

bind irq_router irq_router_chk #(
    .SLOT_W    (SLOT_W),
    .PIN_W     (PIN_W),
    .CFG_W     (CFG_W),
    .LINE_BASE (LINE_BASE),
    .LINE_W    (LINE_W)
) u_chk (.*);

// File: tb/irq_router_test.sv
module irq_router_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_stb = 1'b0;
    logic [4:0]  evt_slot = '0;
    logic [1:0]  evt_pin = '0;
    logic [31:0] edge_cfg = '0;
    logic [31:0] pol_cfg = '0;
    logic [5:0]  line_num;
    logic        cpu_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_stb  (evt_stb),
        .evt_slot (evt_slot),
        .evt_pin  (evt_pin),
        .edge_cfg (edge_cfg),
        .pol_cfg  (pol_cfg),
        .line_num (line_num),
        .cpu_irq  (cpu_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Strobe one event; returns at the falling edge after the capturing edge
    task automatic fire(input int slot, input int pin);
        @(negedge clk);
        evt_slot = 5'(slot);
        evt_pin  = 2'(pin);
        evt_stb  = 1'b1;
        @(negedge clk);
        evt_stb  = 1'b0;
    endtask

    task automatic map_line(input int slot, input int pin, input int exp, input string req);
        @(negedge clk);
        evt_slot = 5'(slot);
        evt_pin  = 2'(pin);
        #1;
        check(req, int'(line_num), exp);
    endtask

    task automatic test_reset();
        check("R9 during reset", int'(cpu_irq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset", int'(cpu_irq), 0);
    endtask

    task automatic test_map();
        for (int p = 0; p < 4; p++) map_line(5, p, 32 + p, "R1");
        map_line(6, 2, 36, "R2");
        map_line(6, 0, 36, "R2");
        map_line(7, 3, 37, "R2");
        map_line(8, 0, 38, "R3");
        map_line(10, 1, 41, "R3");
        map_line(12, 3, 45, "R3");
        map_line(9, 3, 42, "R3");
        map_line(0, 3, 3, "R4");
        map_line(31, 1, 1, "R4");
        map_line(13, 2, 2, "R4");
    endtask

    task automatic test_level();
        edge_cfg = '0;
        pol_cfg  = 32'h0000_0001;
        fire(5, 0);
        check("R7 level high", int'(cpu_irq), 1);
        repeat (3) @(negedge clk);
        check("R7 level hold", int'(cpu_irq), 1);
        fire(6, 1);
        check("R8 level low", int'(cpu_irq), 0);
        repeat (2) @(negedge clk);
        check("R8 level hold", int'(cpu_irq), 0);
    endtask

    task automatic test_ignored();
        fire(2, 1);
        check("R5 ignored while low", int'(cpu_irq), 0);
        fire(5, 0);
        check("R7 raise before ignore", int'(cpu_irq), 1);
        fire(20, 3);
        check("R5 ignored while high", int'(cpu_irq), 1);
        @(negedge clk);
        check("R5 still high", int'(cpu_irq), 1);
        fire(6, 0);
        check("R8 drop", int'(cpu_irq), 0);
    endtask

    task automatic test_edge();
        edge_cfg = 32'h0000_2000;
        pol_cfg  = 32'h0000_0001;
        fire(12, 3);
        check("R6 pulse high", int'(cpu_irq), 1);
        @(negedge clk);
        check("R6 pulse end", int'(cpu_irq), 0);
        fire(5, 0);
        check("R7 high before edge", int'(cpu_irq), 1);
        fire(12, 3);
        check("R6 pulse from high", int'(cpu_irq), 1);
        @(negedge clk);
        check("R6 low after pulse", int'(cpu_irq), 0);
    endtask

    task automatic test_back_to_back();
        edge_cfg = 32'h0000_0040;
        @(negedge clk);
        evt_slot = 5'd8;
        evt_pin  = 2'd0;
        evt_stb  = 1'b1;
        @(negedge clk);
        check("R6 first pulse", int'(cpu_irq), 1);
        @(negedge clk);
        evt_stb = 1'b0;
        check("R6 second pulse", int'(cpu_irq), 1);
        @(negedge clk);
        check("R6 train end", int'(cpu_irq), 0);
    endtask

    task automatic test_bit_index();
        edge_cfg = 32'h0000_1000;
        pol_cfg  = 32'h0000_2000;
        fire(12, 3);
        check("R10 bit13 level high", int'(cpu_irq), 1);
        @(negedge clk);
        check("R10 level hold", int'(cpu_irq), 1);
        pol_cfg = 32'hFFFF_DFFF;
        fire(12, 3);
        check("R10 bit13 pol clear", int'(cpu_irq), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        test_reset();
        test_map();
        test_level();
        test_ignored();
        test_edge();
        test_back_to_back();
        test_bit_index();
        repeat (2) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule